// File: doc/BRIEF.md
# Addressed Multidrop Serial Receiver

This block receives asynchronous serial frames for a microcontroller-style serial port. It covers the two asynchronous frame formats. The short format carries eight data bits and a stop bit. The long format carries eight data bits, a ninth data bit and a stop bit. The line is sampled against a free-running baud tick at sixteen times the bit rate. Each bit is decided by a vote of three samples taken at the middle of the bit.

A finished frame is moved from the shifter into a holding register. The block then raises a sticky "frame ready" flag, and a per-frame status bit carries the ninth bit (long format) or the stop level (short format). On a multidrop bus, an address-filter input makes the receiver drop every frame whose ninth bit is low. In the short format, the same input drops frames with a bad stop bit.

The shifter and the holding register form two stages, so a new frame can arrive while software has not yet read the previous byte. A frame that completes over an unread byte replaces it, and the block flags that loss with a one-cycle pulse. Software clears the ready flag with a strobe of its own. A separate read strobe marks the held byte as consumed.

Top module: `mdrop_rx`

## Requirements
- R1: After reset, `rx_data` is 0, `rx_bit9` is 0, `rx_ready` is 0 and `overrun` is 0.
- R2: A frame begins only on a high-to-low change of `rx_line` seen on consecutive baud ticks while `rx_en` is 1. A frame sent while `rx_en` is 0 leaves all outputs unchanged.
- R3: Each bit is decided by a majority of three samples taken on ticks 7, 8 and 9 of its 16-tick period. Data bits arrive least significant bit first and appear unchanged on `rx_data`.
- R4: With `long_fmt` = 1 and `addr_filter` = 1, a frame whose ninth bit is 0 is discarded: `rx_ready`, `rx_data` and `rx_bit9` do not change. With `addr_filter` = 0, it is accepted.
- R5: With `long_fmt` = 0 and `addr_filter` = 1, a frame whose stop bit samples low is discarded. With `addr_filter` = 0, it is accepted.
- R6: On an accepted frame, `rx_bit9` takes the ninth data bit when `long_fmt` = 1 and the sampled stop level when `long_fmt` = 0.
- R7: `rx_ready` is set by every accepted frame and stays set until a `ready_clr` pulse. `byte_rd` does not clear it.
- R8: `rx_data` changes only when a frame is accepted. If the held byte has not been consumed by `byte_rd` when the next frame is accepted, the new byte replaces it and `overrun` is high for exactly one clock. If `byte_rd` came in between, there is no pulse.
- R9: A start bit whose vote at mid-bit is high is treated as a glitch. The receiver goes back to idle, and a following well-formed frame is received correctly.
- R10: Dropping `rx_en` during a frame abandons it, leaving `rx_ready`, `rx_bit9` and `rx_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-clock pulse at 16x the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_en | input | 1 | Receive enable |
| long_fmt | input | 1 | 1: frame has a ninth data bit; 0: eight bits then stop |
| addr_filter | input | 1 | Multidrop filter enable |
| ready_clr | input | 1 | Software clear of `rx_ready` |
| byte_rd | input | 1 | Read strobe marking the held byte consumed |
| rx_data | output | DATA_W | Holding register |
| rx_bit9 | output | 1 | Ninth bit or stop level of the last accepted frame |
| rx_ready | output | 1 | Sticky frame-ready flag |
| overrun | output | 1 | One-clock pulse when an unread byte is replaced |

## Verification
The bench targets the filter in both formats, with the ninth bit and the stop level each driven both ways. A design that swaps the two conditions, or tests the wrong level, either lets address bytes through or drops data bytes. A glitch start followed at once by a good frame exposes a receiver that stays stuck in the frame or counts the glitch as a start bit. Back-to-back frames, once with a read between them and once without, show whether the loss pulse is missing or spurious. Dropping the enable mid-frame and sending a frame while disabled catch a receiver that keeps counting bits and later reports a corrupt byte.

// File: rtl/mdrop_rx_pkg.sv
package mdrop_rx_pkg;
   typedef enum logic {
      FRM_IDLE = 1'b0,
      FRM_BUSY = 1'b1
   } frm_state_e;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction
endpackage

// File: rtl/mdrop_rx_sync.sv
module mdrop_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mdrop_rx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], d_async};
   end

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/mdrop_rx_sampler.sv
module mdrop_rx_sampler #(
   parameter int OVS   = 16,
   parameter bit VOTE3 = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic line_s,
   input  logic active,
   input  logic phase_load,
   output logic vote_stb,
   output logic vote_bit
);
   import mdrop_rx_pkg::*;

   localparam int PH_W = $clog2(OVS);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);
   localparam logic [PH_W-1:0] PH_A    = PH_W'(OVS / 2 - 1);
   localparam logic [PH_W-1:0] PH_B    = PH_W'(OVS / 2);
   localparam logic [PH_W-1:0] PH_V    = PH_W'(OVS / 2 + 1);

   if (OVS < 4) begin : g_bad_ovs
      $error("mdrop_rx_sampler: OVS must be at least 4");
   end

   logic [PH_W-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          phase_q <= '0;
      else if (phase_load) phase_q <= PH_W'(1);
      else if (tick)       phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + PH_W'(1);
   end

   assign vote_stb = active && tick && (phase_q == PH_V);

   if (VOTE3) begin : g_vote3
      logic samp_a_q, samp_b_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            samp_a_q <= 1'b1;
            samp_b_q <= 1'b1;
         end else if (tick) begin
            if (phase_q == PH_A) samp_a_q <= line_s;
            if (phase_q == PH_B) samp_b_q <= line_s;
         end
      end
      assign vote_bit = maj3(samp_a_q, samp_b_q, line_s);
   end else begin : g_vote1
      assign vote_bit = line_s;
   end

   // R3: one decision per bit period, never two in a row
   assert_one_vote_per_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      vote_stb |=> !vote_stb);
endmodule

// File: rtl/mdrop_rx_frame.sv
module mdrop_rx_frame #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              line_s,
   input  logic              rx_en,
   input  logic              long_fmt,
   input  logic              vote_stb,
   input  logic              vote_bit,
   output logic              busy,
   output logic              phase_load,
   output logic              done,
   output logic [DATA_W-1:0] frm_data,
   output logic              frm_b9
);
   import mdrop_rx_pkg::*;

   localparam int IDX_W = $clog2(DATA_W + 3);
   localparam logic [IDX_W-1:0] IDX_LASTD = IDX_W'(DATA_W);
   localparam logic [IDX_W-1:0] IDX_NINTH = IDX_W'(DATA_W + 1);

   frm_state_e       state_q;
   logic [IDX_W-1:0] idx_q;
   logic             prev_line_q;
   logic             start;

   assign start      = tick && (state_q == FRM_IDLE) && rx_en && prev_line_q && !line_s;
   assign phase_load = start;
   assign busy       = (state_q == FRM_BUSY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    prev_line_q <= 1'b1;
      else if (tick) prev_line_q <= line_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= FRM_IDLE;
         idx_q    <= '0;
         done     <= 1'b0;
         frm_data <= '0;
         frm_b9   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!rx_en) begin
            state_q <= FRM_IDLE;
         end else if (state_q == FRM_IDLE) begin
            if (start) begin
               state_q <= FRM_BUSY;
               idx_q   <= '0;
            end
         end else if (vote_stb) begin
            if (idx_q == '0) begin
               if (vote_bit) state_q <= FRM_IDLE;
               else          idx_q   <= IDX_W'(1);
            end else if (idx_q <= IDX_LASTD) begin
               frm_data <= {vote_bit, frm_data[DATA_W-1:1]};
               idx_q    <= idx_q + IDX_W'(1);
            end else if (idx_q == IDX_NINTH) begin
               frm_b9 <= vote_bit;
               if (long_fmt) begin
                  idx_q <= idx_q + IDX_W'(1);
               end else begin
                  state_q <= FRM_IDLE;
                  done    <= 1'b1;
               end
            end else begin
               state_q <= FRM_IDLE;
               done    <= 1'b1;
            end
         end
      end
   end

   // R10: a disabled receiver is idle on the next clock
   assert_abort_on_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !busy);
   // R2: a frame starts only on a line that is low
   assert_start_needs_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !$past(line_s));
endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx #(
   parameter int DATA_W    = 8,
   parameter int OVS       = 16,
   parameter bit VOTE3     = 1'b1,
   parameter int SYNC_STGS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              rx_line,
   input  logic              rx_en,
   input  logic              long_fmt,
   input  logic              addr_filter,
   input  logic              ready_clr,
   input  logic              byte_rd,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_bit9,
   output logic              rx_ready,
   output logic              overrun
);
   if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
      $error("mdrop_rx: DATA_W must lie in 5..9");
   end

   logic              line_s;
   logic              busy, phase_load, vote_stb, vote_bit, frm_done, frm_b9;
   logic [DATA_W-1:0] frm_data;
   logic              unread_q;
   logic              accept;

   mdrop_rx_sync #(.STAGES(SYNC_STGS)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(rx_line), .q_sync(line_s));

   mdrop_rx_sampler #(.OVS(OVS), .VOTE3(VOTE3)) u_samp (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .line_s(line_s),
      .active(busy), .phase_load(phase_load),
      .vote_stb(vote_stb), .vote_bit(vote_bit));

   mdrop_rx_frame #(.DATA_W(DATA_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .line_s(line_s),
      .rx_en(rx_en), .long_fmt(long_fmt),
      .vote_stb(vote_stb), .vote_bit(vote_bit),
      .busy(busy), .phase_load(phase_load), .done(frm_done),
      .frm_data(frm_data), .frm_b9(frm_b9));

   // Filter: ninth bit in long format, stop level in short format; both sit in frm_b9
   assign accept = frm_done && (!addr_filter || frm_b9);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data  <= '0;
         rx_bit9  <= 1'b0;
         rx_ready <= 1'b0;
         unread_q <= 1'b0;
         overrun  <= 1'b0;
      end else begin
         overrun <= 1'b0;
         if (accept) begin
            rx_data  <= frm_data;
            rx_bit9  <= frm_b9;
            rx_ready <= 1'b1;
            unread_q <= 1'b1;
            overrun  <= unread_q && !byte_rd;
         end else begin
            if (byte_rd)   unread_q <= 1'b0;
            if (ready_clr) rx_ready <= 1'b0;
         end
      end
   end

   // R7: only the software strobe lowers the ready flag
   assert_ready_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready && !ready_clr |=> rx_ready);
   // R8: the holding register moves only after a finished frame
   assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_done |=> $stable(rx_data));
   // R8: a loss pulse comes with a freshly raised ready flag
   assert_overrun_with_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> rx_ready && !$past(overrun));
   // R4: filtered long frames with a low ninth bit never raise the flag
   assert_filter_long_R4: assert property (@(posedge clk) disable iff (!rst_n)
      frm_done && long_fmt && addr_filter && !frm_b9 |=> !$rose(rx_ready));
   // R5: filtered short frames with a bad stop bit never raise the flag
   assert_filter_short_R5: assert property (@(posedge clk) disable iff (!rst_n)
      frm_done && !long_fmt && addr_filter && !frm_b9 |=> !$rose(rx_ready));
endmodule

// File: tb/mdrop_rx_tb.sv
`timescale 1ns/100ps
module mdrop_rx_tb_top;
   localparam int BIT_CLKS = 64;  // 16 ticks of 4 clocks

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_line = 1'b1, rx_en = 1'b0, long_fmt = 1'b0, addr_filter = 1'b0;
   logic       ready_clr = 1'b0, byte_rd = 1'b0;
   logic [7:0] rx_data;
   logic       rx_bit9, rx_ready, overrun;
   logic [1:0] tcnt = 2'd0;
   logic       baud_tick;
   int         checks = 0, fails = 0, ovr_pulses = 0;

   always #2.5 clk = ~clk;
   always_ff @(posedge clk) tcnt <= tcnt + 2'd1;
   assign baud_tick = (tcnt == 2'd3);
   always @(negedge clk) if (rst_n && overrun) ovr_pulses++;

   mdrop_rx dut_i (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_line(rx_line),
      .rx_en(rx_en), .long_fmt(long_fmt), .addr_filter(addr_filter),
      .ready_clr(ready_clr), .byte_rd(byte_rd), .rx_data(rx_data),
      .rx_bit9(rx_bit9), .rx_ready(rx_ready), .overrun(overrun));

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk) rx_line = b;
      repeat (BIT_CLKS - 1) @(negedge clk);
   endtask

   // last9 = ninth bit when long, stop level when short
   task automatic send_frame(input logic [7:0] d, input logic last9);
      send_bit(1'b1);
      send_bit(1'b0);
      for (int i = 0; i < 8; i++) send_bit(d[i]);
      send_bit(last9);
      if (long_fmt) send_bit(1'b1);
      send_bit(1'b1);
      repeat (8) @(negedge clk);
   endtask

   task automatic service();
      @(negedge clk) begin byte_rd = 1'b1; ready_clr = 1'b1; end
      @(negedge clk) begin byte_rd = 1'b0; ready_clr = 1'b0; end
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 data", 16'(rx_data), 16'h0);
      check("R1 bit9", 16'(rx_bit9), 16'h0);
      check("R1 ready", 16'(rx_ready), 16'h0);
      check("R1 overrun", 16'(overrun), 16'h0);
   endtask

   task automatic t_short_fmt();
      long_fmt = 1'b0; addr_filter = 1'b0;
      send_frame(8'hA5, 1'b1);
      check("R3 data A5", 16'(rx_data), 16'h00A5);
      check("R6 stop level 1", 16'(rx_bit9), 16'h1);
      check("R7 ready set", 16'(rx_ready), 16'h1);
      @(negedge clk) byte_rd = 1'b1;
      @(negedge clk) byte_rd = 1'b0;
      check("R7 read keeps ready", 16'(rx_ready), 16'h1);
      service();
      check("R7 clr drops ready", 16'(rx_ready), 16'h0);
      send_frame(8'h3C, 1'b0);
      check("R5 bad stop accepted unfiltered", 16'(rx_ready), 16'h1);
      check("R3 data 3C", 16'(rx_data), 16'h003C);
      check("R6 stop level 0", 16'(rx_bit9), 16'h0);
      service();
      addr_filter = 1'b1;
      send_frame(8'h81, 1'b0);
      check("R5 bad stop dropped", 16'(rx_ready), 16'h0);
      check("R5 data kept", 16'(rx_data), 16'h003C);
      send_frame(8'h81, 1'b1);
      check("R5 good stop accepted", 16'(rx_ready), 16'h1);
      check("R3 data 81", 16'(rx_data), 16'h0081);
      service();
   endtask

   task automatic t_long_fmt();
      long_fmt = 1'b1; addr_filter = 1'b1;
      send_frame(8'h5A, 1'b0);
      check("R4 ninth 0 dropped", 16'(rx_ready), 16'h0);
      check("R4 data kept", 16'(rx_data), 16'h0081);
      check("R4 bit9 kept", 16'(rx_bit9), 16'h1);
      send_frame(8'h12, 1'b1);
      check("R4 ninth 1 accepted", 16'(rx_ready), 16'h1);
      check("R6 ninth 1", 16'(rx_bit9), 16'h1);
      check("R3 data 12", 16'(rx_data), 16'h0012);
      service();
      addr_filter = 1'b0;
      send_frame(8'hE7, 1'b0);
      check("R4 ninth 0 unfiltered", 16'(rx_ready), 16'h1);
      check("R6 ninth 0", 16'(rx_bit9), 16'h0);
      check("R3 data E7", 16'(rx_data), 16'h00E7);
      service();
      long_fmt = 1'b0;
   endtask

   task automatic t_enable();
      rx_en = 1'b0;
      send_frame(8'h77, 1'b1);
      check("R2 disabled ready", 16'(rx_ready), 16'h0);
      check("R2 disabled data", 16'(rx_data), 16'h00E7);
      rx_en = 1'b1;
      send_bit(1'b1);
      send_bit(1'b0);
      send_bit(1'b0);
      send_bit(1'b1);
      @(negedge clk) rx_en = 1'b0;
      for (int i = 0; i < 8; i++) send_bit(i[0]);
      check("R10 abort ready", 16'(rx_ready), 16'h0);
      check("R10 abort data", 16'(rx_data), 16'h00E7);
      check("R10 abort bit9", 16'(rx_bit9), 16'h0);
      rx_en = 1'b1;
      send_frame(8'h4B, 1'b1);
      check("R10 recovers data", 16'(rx_data), 16'h004B);
      service();
   endtask

   task automatic t_glitch();
      send_bit(1'b1);
      @(negedge clk) rx_line = 1'b0;
      repeat (16) @(negedge clk);
      rx_line = 1'b1;
      repeat (3 * BIT_CLKS) @(negedge clk);
      check("R9 glitch ignored", 16'(rx_ready), 16'h0);
      send_frame(8'hC3, 1'b1);
      check("R9 next frame data", 16'(rx_data), 16'h00C3);
      check("R9 next frame ready", 16'(rx_ready), 16'h1);
      service();
   endtask

   task automatic t_double_buffer();
      int base;
      base = ovr_pulses;
      send_frame(8'h11, 1'b1);
      @(negedge clk) byte_rd = 1'b1;
      @(negedge clk) byte_rd = 1'b0;
      send_frame(8'h22, 1'b1);
      check("R8 read between no overrun", 16'(ovr_pulses - base), 16'h0);
      check("R8 data 22", 16'(rx_data), 16'h0022);
      send_frame(8'h33, 1'b1);
      check("R8 overwrite pulse count", 16'(ovr_pulses - base), 16'h1);
      check("R8 overwrite data", 16'(rx_data), 16'h0033);
      service();
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      rx_en = 1'b1;
      repeat (4) @(negedge clk);
      t_short_fmt();
      t_long_fmt();
      t_enable();
      t_glitch();
      t_double_buffer();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule